// File: doc/BRIEF.md
# RTC Alarm and Watchdog Control

This block keeps a free-running seconds count, compares it against a programmable alarm time and runs a countdown watchdog. It sits behind a simple register bus (address, write data, write strobe, combinational read data). Three of its registers (control, persistent 0 and persistent 1) can be written in three ways: a plain write at the base offset, a set alias that ORs a mask in, and a clear alias that removes a mask. This lets software flip single bits without a read-modify-write race. The seconds, alarm and watchdog count registers take plain writes only.

Two tick inputs pace the block. A one-second tick advances the seconds count, and a one-millisecond tick decrements the watchdog. When the alarm function is enabled and the seconds count comes to equal the alarm value, the alarm flag is raised. The interrupt line follows the flag gated by its enable, and a wake status bit is raised if wake is enabled. When the watchdog is enabled with a non-zero count, it decrements each millisecond tick. On reaching zero it emits a one-cycle reset request and stops. The oscillator selection bits, the millisecond interrupt enable and persistent 1 are storage only.

Two state machines carry the control. The alarm machine has states AL_WAIT and AL_HELD. It moves AL_WAIT to AL_HELD when the match condition (alarm enable and equal values) starts, raising the match event on that transition. It moves AL_HELD to AL_WAIT when the condition ends. The watchdog machine has states WD_IDLE, WD_COUNT and WD_FIRE. WD_IDLE goes to WD_COUNT when the enable is set and the count is non-zero. WD_COUNT goes to WD_IDLE when the enable is cleared or the count is found zero. WD_COUNT goes to WD_FIRE when a millisecond tick takes the count from 1 to 0. WD_FIRE always returns to WD_IDLE after one cycle.

Top module: `rtc_awd_ctl`

## Requirements
- R1: After reset every register reads 0 and alarm_irq, wake_req and wdog_rst are low.
- R2: A plain write at a register's base offset replaces it. Only defined bits are kept: control keeps bits 0,1,2,4 (mask 0x17), persistent 0 keeps bits 0,1,2,4,5,6,7 (mask 0xF7), and persistent 1 keeps all 32 bits. Undefined bits read 0.
- R3: For control (0x00), persistent 0 (0x60) and persistent 1 (0x70), a write at base+0x4 sets the masked bits, and a write at base+0x8 clears the bits given. All other bits are unchanged. Reads at either alias return the register value.
- R4: Seconds (0x30) increments by one on each sec_tick and wraps from 0xFFFFFFFF to 0. A bus write to it in the same cycle as a tick wins.
- R5: When alarm enable (persistent 0 bit 2) is set and the seconds count starts to equal the alarm value (0x40), the alarm flag (control bit 2) is set in the following cycle. With alarm enable clear, no flag is raised.
- R6: The flag is raised once per period of equality. Clearing it while seconds still equals the alarm value does not raise it again.
- R7: alarm_irq is high exactly while the alarm flag and the alarm interrupt enable (control bit 0) are both set.
- R8: The wake status (persistent 0 bit 7) is set together with the alarm flag only if alarm wake enable (persistent 0 bit 1) is set. wake_req follows the wake status.
- R9: The alarm flag and wake status are acknowledged by writing their bits to the clear alias of their register.
- R10: With watchdog enable (control bit 4) set and a non-zero count at 0x50, counting starts on the cycle after, and the count decrements by one per ms_tick. The count stays readable.
- R11: When the count reaches 0, wdog_rst pulses high for exactly one cycle and the watchdog stops. A zero count never restarts it.
- R12: Clearing watchdog enable halts the countdown and holds the count. While disabled, ms_tick has no effect on the count.
- R13: Persistent 0 bits 0,4,5,6, control bit 1 and persistent 1 are stored and read back but change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| sec_tick | input | 1 | One-second tick, one cycle wide |
| ms_tick | input | 1 | One-millisecond tick, one cycle wide |
| alarm_irq | output | 1 | Alarm interrupt line |
| wake_req | output | 1 | Wake request from alarm |
| wdog_rst | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit address, and 32-bit seconds and watchdog counters. The wrap of the seconds count is reached by loading it just below its maximum rather than by ticking. Short watchdog loads of 3 and 5 bring the 1-to-0 transition, the single reset pulse and the halt-on-disable path within a few dozen cycles. Alarm values just ahead of the current seconds show the enable gating, the once-per-equality rule and the wake path.

// File: rtl/rtc_awd_pkg.sv
package rtc_awd_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_AREGS = 3;

    // register byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_SECS = 'h30;
    localparam int OFS_ALRM = 'h40;
    localparam int OFS_WDOG = 'h50;
    localparam int OFS_PST0 = 'h60;
    localparam int OFS_PST1 = 'h70;

    // alias displacement from a register base
    localparam int ALIAS_SET = 'h4;
    localparam int ALIAS_CLR = 'h8;

    // control bits
    localparam int CTL_AIRQ_EN = 0;
    localparam int CTL_MSIRQ_EN = 1;
    localparam int CTL_AFLAG   = 2;
    localparam int CTL_WD_EN   = 4;

    // persistent 0 bits
    localparam int P0_WAKE_EN  = 1;
    localparam int P0_ALM_EN   = 2;
    localparam int P0_WAKE_ST  = 7;

    localparam logic [REG_W-1:0] CTRL_MASK = 32'h0000_0017;
    localparam logic [REG_W-1:0] PST0_MASK = 32'h0000_00F7;
    localparam logic [REG_W-1:0] PST1_MASK = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {ACC_NONE, ACC_PLAIN, ACC_SET, ACC_CLR} acc_e;
    typedef enum logic {AL_WAIT, AL_HELD} al_state_e;
    typedef enum logic [1:0] {WD_IDLE, WD_COUNT, WD_FIRE} wd_state_e;

    function automatic int areg_base(input int idx);
        case (idx)
            0:       return OFS_CTRL;
            1:       return OFS_PST0;
            default: return OFS_PST1;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] areg_mask(input int idx);
        case (idx)
            0:       return CTRL_MASK;
            1:       return PST0_MASK;
            default: return PST1_MASK;
        endcase
    endfunction

endpackage

// File: rtl/rtc_awd_alias_reg.sv
module rtc_awd_alias_reg
    import rtc_awd_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              W      = 32,
    parameter int              BASE   = 0,
    parameter logic [W-1:0]    MASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      hw_set,
    output logic [W-1:0]      q
);

    localparam logic [ADDR_W-1:0] A_PLAIN = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(BASE + ALIAS_SET);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(BASE + ALIAS_CLR);

    acc_e          acc;
    logic [W-1:0]  q_nxt;

    always_comb begin
        acc = ACC_NONE;
        if (wr_en) begin
            if (addr == A_PLAIN)    acc = ACC_PLAIN;
            else if (addr == A_SET) acc = ACC_SET;
            else if (addr == A_CLR) acc = ACC_CLR;
        end
    end

    always_comb begin
        q_nxt = q;
        unique case (acc)
            ACC_NONE:  q_nxt = q;
            ACC_PLAIN: q_nxt = wdata & MASK;
            ACC_SET:   q_nxt = q | (wdata & MASK);
            ACC_CLR:   q_nxt = q & ~wdata;
        endcase
        // a hardware event in the same cycle is never lost
        q_nxt = q_nxt | (hw_set & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_CLR && hw_set == '0) |=> ((q & $past(wdata)) == '0));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_SET) |=> ((q & $past(wdata) & MASK) == ($past(wdata) & MASK)));

    assert_plain_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((q & ~MASK) == '0));

endmodule

// File: rtl/rtc_awd_alarm.sv
module rtc_awd_alarm
    import rtc_awd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              sec_tick,
    input  logic              alarm_en,
    output logic [SEC_W-1:0]  seconds,
    output logic [SEC_W-1:0]  alarm_val,
    output logic              match_evt
);

    logic      wr_sec;
    logic      wr_alm;
    logic      eq;
    al_state_e st;
    al_state_e st_nxt;

    assign wr_sec = wr_en && (addr == ADDR_W'(OFS_SECS));
    assign wr_alm = wr_en && (addr == ADDR_W'(OFS_ALRM));
    assign eq     = alarm_en && (seconds == alarm_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seconds   <= '0;
            alarm_val <= '0;
        end else begin
            if (wr_sec)        seconds <= wdata[SEC_W-1:0];
            else if (sec_tick) seconds <= seconds + SEC_W'(1);
            if (wr_alm)        alarm_val <= wdata[SEC_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= AL_WAIT;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            AL_WAIT: st_nxt = eq ? AL_HELD : AL_WAIT;
            AL_HELD: st_nxt = eq ? AL_HELD : AL_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        match_evt = 1'b0;
        unique case (st)
            AL_WAIT: match_evt = eq;
            AL_HELD: match_evt = 1'b0;
        endcase
    end

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_sec && seconds == '1) |=> (seconds == '0));

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> (seconds == $past(wdata[SEC_W-1:0])));

    assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> !match_evt);

endmodule

// File: rtl/rtc_awd_wdog.sv
module rtc_awd_wdog
    import rtc_awd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              ms_tick,
    input  logic              wd_en,
    output logic [WD_W-1:0]   count,
    output logic              rst_pulse
);

    logic      wr_cnt;
    logic      dec;
    wd_state_e st;
    wd_state_e st_nxt;

    assign wr_cnt = wr_en && (addr == ADDR_W'(OFS_WDOG));
    assign dec    = (st == WD_COUNT) && wd_en && !wr_cnt && ms_tick && (count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (wr_cnt) count <= wdata[WD_W-1:0];
        else if (dec)    count <= count - WD_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            WD_IDLE: begin
                if (wd_en && count != '0) st_nxt = WD_COUNT;
            end
            WD_COUNT: begin
                if (!wd_en)                           st_nxt = WD_IDLE;
                else if (wr_cnt)                      st_nxt = WD_COUNT;
                else if (count == '0)                 st_nxt = WD_IDLE;
                else if (ms_tick && count == WD_W'(1)) st_nxt = WD_FIRE;
            end
            WD_FIRE: st_nxt = WD_IDLE;
            default: st_nxt = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rst_pulse = 1'b0;
        unique case (st)
            WD_FIRE: rst_pulse = 1'b1;
            default: rst_pulse = 1'b0;
        endcase
    end

    assert_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_COUNT && wd_en && ms_tick && !wr_cnt && count != '0)
        |=> (count == $past(count) - WD_W'(1)));

    assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    assert_fire_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (count == '0));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && !wr_cnt) |=> $stable(count));

endmodule

// File: rtl/rtc_awd_ctl.sv
module rtc_awd_ctl
    import rtc_awd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 32,
    parameter int WD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic              sec_tick,
    input  logic              ms_tick,
    output logic              alarm_irq,
    output logic              wake_req,
    output logic              wdog_rst
);

    localparam int IDX_CTRL = 0;
    localparam int IDX_PST0 = 1;
    localparam int IDX_PST1 = 2;

    logic [NUM_AREGS-1:0][REG_W-1:0] areg_q;
    logic [NUM_AREGS-1:0][REG_W-1:0] areg_hw;
    logic [SEC_W-1:0]                seconds;
    logic [SEC_W-1:0]                alarm_val;
    logic [WD_W-1:0]                 wd_count;
    logic                            alarm_evt;
    logic [REG_W-1:0]                ctrl_q;
    logic [REG_W-1:0]                pst0_q;

    assign ctrl_q = areg_q[IDX_CTRL];
    assign pst0_q = areg_q[IDX_PST0];

    always_comb begin
        areg_hw = '0;
        areg_hw[IDX_CTRL][CTL_AFLAG]  = alarm_evt;
        areg_hw[IDX_PST0][P0_WAKE_ST] = alarm_evt && pst0_q[P0_WAKE_EN];
    end

    for (genvar g = 0; g < NUM_AREGS; g++) begin : g_areg
        rtc_awd_alias_reg #(
            .ADDR_W (ADDR_W),
            .W      (REG_W),
            .BASE   (areg_base(g)),
            .MASK   (areg_mask(g))
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we),
            .addr   (bus_addr),
            .wdata  (bus_wdata),
            .hw_set (areg_hw[g]),
            .q      (areg_q[g])
        );
    end

    rtc_awd_alarm #(
        .ADDR_W (ADDR_W),
        .SEC_W  (SEC_W)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .sec_tick  (sec_tick),
        .alarm_en  (pst0_q[P0_ALM_EN]),
        .seconds   (seconds),
        .alarm_val (alarm_val),
        .match_evt (alarm_evt)
    );

    rtc_awd_wdog #(
        .ADDR_W (ADDR_W),
        .WD_W   (WD_W)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ms_tick   (ms_tick),
        .wd_en     (ctrl_q[CTL_WD_EN]),
        .count     (wd_count),
        .rst_pulse (wdog_rst)
    );

    // read mux: aliases read back their register
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_AREGS; i++) begin
            if (bus_addr == ADDR_W'(areg_base(i)) ||
                bus_addr == ADDR_W'(areg_base(i) + ALIAS_SET) ||
                bus_addr == ADDR_W'(areg_base(i) + ALIAS_CLR))
                bus_rdata = areg_q[i];
        end
        if (bus_addr == ADDR_W'(OFS_SECS)) bus_rdata = REG_W'(seconds);
        if (bus_addr == ADDR_W'(OFS_ALRM)) bus_rdata = REG_W'(alarm_val);
        if (bus_addr == ADDR_W'(OFS_WDOG)) bus_rdata = REG_W'(wd_count);
    end

    assign alarm_irq = ctrl_q[CTL_AFLAG] && ctrl_q[CTL_AIRQ_EN];
    assign wake_req  = pst0_q[P0_WAKE_ST];

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> ctrl_q[CTL_AFLAG]);

    assert_wake_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && pst0_q[P0_WAKE_EN]) |=> wake_req);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> ctrl_q[CTL_AIRQ_EN]);

endmodule

// File: tb/sim_rtc_awd_ctl.sv
module sim_rtc_awd_ctl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        sec_tick = 1'b0;
    logic        ms_tick = 1'b0;
    logic        alarm_irq;
    logic        wake_req;
    logic        wdog_rst;

    int compared = 0;
    int mismatched = 0;
    logic smp = 1'b0;
    bit done = 1'b0;

    // scoreboard queues: kind 0 = register read, 1 = irq, 2 = wake, 3 = wdog reset
    int          kind_q[$];
    logic [31:0] val_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_awd_ctl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .sec_tick  (sec_tick),
        .ms_tick   (ms_tick),
        .alarm_irq (alarm_irq),
        .wake_req  (wake_req),
        .wdog_rst  (wdog_rst)
    );

    // monitor: pops one expected item per sampled cycle
    always @(negedge clk) begin
        int          k;
        logic [31:0] ev;
        logic [31:0] act;
        string       t;
        #2;
        if (smp && kind_q.size() > 0) begin
            k  = kind_q.pop_front();
            ev = val_q.pop_front();
            t  = tag_q.pop_front();
            case (k)
                0:       act = bus_rdata;
                1:       act = {31'b0, alarm_irq};
                2:       act = {31'b0, wake_req};
                default: act = {31'b0, wdog_rst};
            endcase
            compared++;
            if (act !== ev) begin
                mismatched++;
                $display("FAIL %s: actual %08h expected %08h", t, act, ev);
            end
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic stick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic mtick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] v, input string t);
        bus_addr = a;
        kind_q.push_back(0); val_q.push_back(v); tag_q.push_back(t);
        smp = 1'b1;
        @(negedge clk);
        smp = 1'b0;
    endtask

    task automatic exp_out(input int k, input logic v, input string t);
        kind_q.push_back(k); val_q.push_back({31'b0, v}); tag_q.push_back(t);
        smp = 1'b1;
        @(negedge clk);
        smp = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_rd(8'h00, 32'h0, "R1 ctrl");
        exp_rd(8'h30, 32'h0, "R1 seconds");
        exp_rd(8'h60, 32'h0, "R1 pst0");
        exp_out(1, 1'b0, "R1 irq");
        exp_out(2, 1'b0, "R1 wake");
        exp_out(3, 1'b0, "R1 wdog");

        // R2 plain writes keep only defined bits
        wr(8'h00, 32'hFFFF_FFFF);
        exp_rd(8'h00, 32'h17, "R2 ctrl mask");
        exp_out(1, 1'b1, "R7 irq with flag and enable");
        wr(8'h00, 32'h0);
        exp_rd(8'h00, 32'h0, "R2 ctrl replace");
        exp_out(1, 1'b0, "R7 irq cleared");
        wr(8'h70, 32'h8000_0001);
        exp_rd(8'h70, 32'h8000_0001, "R2 pst1 full");

        // R3 set / clear aliases
        wr(8'h04, 32'h11);
        exp_rd(8'h00, 32'h11, "R3 set");
        wr(8'h04, 32'h02);
        exp_rd(8'h00, 32'h13, "R3 set keeps others");
        wr(8'h08, 32'h01);
        exp_rd(8'h00, 32'h12, "R3 clr");
        exp_rd(8'h04, 32'h12, "R3 alias readback");
        wr(8'h08, 32'hFFFF_FFFF);
        exp_rd(8'h08, 32'h0, "R3 clr all");

        // R4 seconds count, wrap, write priority
        wr(8'h30, 32'hFFFF_FFFE);
        stick();
        exp_rd(8'h30, 32'hFFFF_FFFF, "R4 increment");
        stick();
        exp_rd(8'h30, 32'h0, "R4 wrap");
        bus_addr = 8'h30; bus_wdata = 32'd100; bus_we = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; sec_tick = 1'b0;
        exp_rd(8'h30, 32'd100, "R4 write wins");
        stick();
        exp_rd(8'h30, 32'd101, "R4 tick after write");

        // R5 no flag while alarm disabled
        wr(8'h40, 32'd105);
        repeat (4) stick();
        idle(1);
        exp_rd(8'h00, 32'h0, "R5 disabled no flag");

        // R5 match with alarm enabled
        wr(8'h40, 32'd108);
        wr(8'h64, 32'h04);
        stick(); stick();
        idle(1);
        exp_rd(8'h00, 32'h0, "R5 before match");
        stick();
        idle(1);
        exp_rd(8'h00, 32'h04, "R5 flag on match");
        exp_out(1, 1'b0, "R7 irq gated by enable");
        exp_out(2, 1'b0, "R8 no wake without enable");
        exp_rd(8'h60, 32'h04, "R8 wake status clear");

        // R6 / R9 acknowledge while equality persists
        wr(8'h08, 32'h04);
        idle(2);
        exp_rd(8'h00, 32'h0, "R6 R9 no re-raise after ack");

        // R7 / R8 interrupt and wake path
        wr(8'h04, 32'h01);
        wr(8'h40, 32'd110);
        wr(8'h64, 32'h02);
        stick(); stick();
        idle(1);
        exp_rd(8'h00, 32'h05, "R7 flag with enable");
        exp_out(1, 1'b1, "R7 irq high");
        exp_rd(8'h60, 32'h86, "R8 wake status set");
        exp_out(2, 1'b1, "R8 wake high");

        // R9 acknowledge
        wr(8'h08, 32'h04);
        exp_out(1, 1'b0, "R9 irq after ack");
        exp_rd(8'h00, 32'h01, "R9 ctrl after ack");
        wr(8'h68, 32'h80);
        exp_out(2, 1'b0, "R9 wake after ack");
        exp_rd(8'h60, 32'h06, "R9 pst0 after ack");

        // R13 storage-only bits
        wr(8'h64, 32'h71);
        wr(8'h04, 32'h02);
        exp_rd(8'h60, 32'h77, "R13 pst0 readback");
        exp_rd(8'h00, 32'h03, "R13 ctrl readback");
        exp_out(1, 1'b0, "R13 irq unchanged");
        exp_out(2, 1'b0, "R13 wake unchanged");
        exp_out(3, 1'b0, "R13 wdog unchanged");
        exp_rd(8'h70, 32'h8000_0001, "R13 pst1 readback");
        wr(8'h68, 32'h04);
        wr(8'h08, 32'hFF);

        // R10 / R11 watchdog countdown and pulse
        wr(8'h50, 32'd3);
        wr(8'h04, 32'h10);
        idle(1);
        mtick();
        exp_rd(8'h50, 32'd2, "R10 decrement");
        mtick();
        exp_rd(8'h50, 32'd1, "R10 decrement again");
        exp_out(3, 1'b0, "R10 no reset yet");
        mtick();
        exp_out(3, 1'b1, "R11 reset pulse");
        exp_out(3, 1'b0, "R11 pulse one cycle");
        exp_rd(8'h50, 32'd0, "R11 count zero");
        mtick();
        exp_out(3, 1'b0, "R11 stopped");

        // R12 disable halts countdown
        wr(8'h08, 32'h10);
        wr(8'h50, 32'd5);
        mtick(); mtick();
        exp_rd(8'h50, 32'd5, "R12 ignored while disabled");
        wr(8'h04, 32'h10);
        idle(1);
        mtick(); mtick();
        exp_rd(8'h50, 32'd3, "R10 counting after enable");
        wr(8'h08, 32'h10);
        mtick(); mtick(); mtick();
        exp_rd(8'h50, 32'd3, "R12 held after disable");
        exp_out(3, 1'b0, "R12 no reset");

        idle(2);
        done = 1'b1;
        report();
    end

endmodule